// File: doc/BRIEF.md
# Configuration Start Sequencer with Lockout

This block starts a configuration source once power comes up. After a full power-up reset it records the delay-select pin and then counts down a power-on interval with a free-running system clock. The interval is short (`SHORT_MS`) or long (`LONG_MS`), and its length in cycles is set by `CYC_PER_MS`. The interval restarts whenever the supply-good input drops. When the interval expires, the output-enable line goes high.

On the clock edge that follows the rise of output-enable, the block takes one sample of the done/select input and makes its only go/no-go decision. A low sample starts a serial stream. The block draws words from a simple word port and shifts each one out most-significant bit first on a data line, under a clock that runs at half the system rate. A high sample puts the block in a silent lockout. Nothing brings it out of lockout except another power-up reset. If the done input rises while the stream is running, streaming stops and the block reports a completed state that is distinct from lockout.

Top module: `cfg_start_seq`

## Requirements
- R1: While `pwr_rst_n` is low, `oe_out`, `cfg_clk`, `cfg_dat` and `word_take` are 0 and `phase` is 0 (power-on countdown).
- R2: `por_short` is captured on the first rising clock edge after reset release and is never sampled again. Captured 1 selects `SHORT_MS*CYC_PER_MS` countdown cycles; captured 0 selects `LONG_MS*CYC_PER_MS` countdown cycles.
- R3: With `supply_ok` held high, `oe_out` rises on rising edge number L+1 after reset release, where L is the selected count. It then stays high until the next reset.
- R4: `supply_ok` low at any rising edge before expiry clears the count. `oe_out` then rises on the L-th rising edge after `supply_ok` returns high.
- R5: `phase` reads 1 (armed) for exactly the one cycle in which `oe_out` first reads high. At the next edge `done_sense` is sampled. A high sample gives `phase` 3 (lockout); a low sample gives `phase` 2 (streaming).
- R6: In lockout, `cfg_clk` and `cfg_dat` stay 0 and `phase` stays 3 whatever `done_sense`, `supply_ok` or `por_short` do. Only `pwr_rst_n` leaves it.
- R7: While streaming, `cfg_clk` is 0 in the first cycle and toggles every cycle after that. Each bit lasts two cycles (clock low, then high), and `cfg_dat` changes only where `cfg_clk` falls.
- R8: Words leave MSB first. `word_take` is high in the cycle before each edge that captures `word_in`: in the armed cycle when the sample is low, and in the clock-high cycle of each word's last bit. That gives one capture every 2*`WORD_W` cycles.
- R9: `done_sense` high at a rising edge while streaming moves `phase` to 4 (complete) at that edge. `cfg_clk` and `cfg_dat` are then held at 0, and `phase` stays 4 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| pwr_rst_n | input | 1 | Full power-up reset, active low, asynchronous |
| por_short | input | 1 | Delay select: 1 short, 0 long (captured once) |
| supply_ok | input | 1 | Supply-good; low holds and restarts the countdown |
| done_sense | input | 1 | Target done / select sense |
| word_in | input | WORD_W | Next configuration word |
| word_take | output | 1 | `word_in` is captured at the coming edge |
| oe_out | output | 1 | Output-enable, low during the countdown |
| cfg_clk | output | 1 | Configuration clock, half system rate |
| cfg_dat | output | 1 | Serial configuration data |
| phase | output | 3 | 0 countdown, 1 armed, 2 streaming, 3 lockout, 4 complete |

## Verification
`oe_out` is due on edge L+1 after reset release (edge 1 captures the select pin), or on the L-th edge after `supply_ok` returns. The bench waits exactly that many edges and checks the value one edge early and at the due edge. The decision appears one edge after `oe_out` rises, and a completion appears at the same edge that sees `done_sense` high. Stream bits are checked at every falling clock: cycle k after entry must carry clock k mod 2 and bit 7-(k/2 mod 8) of word k/16. All inputs change and all outputs are sampled at falling edges, so each expected value is tied to a counted rising edge.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    PH_POR  = 3'd0,
    PH_ARM  = 3'd1,
    PH_RUN  = 3'd2,
    PH_LOCK = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

  // countdown length in system cycles for a given select value
  function automatic int unsigned por_cycles(input logic short_sel,
                                             input int unsigned short_ms,
                                             input int unsigned long_ms,
                                             input int unsigned cyc_per_ms);
    return (short_sel ? short_ms : long_ms) * cyc_per_ms;
  endfunction

  // width needed to hold values 0..n
  function automatic int unsigned width_for(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned SHORT_CYC = 10,
  parameter int unsigned LONG_CYC  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_pin,
  input  logic supply_ok,
  output logic sel_latched,
  output logic sel_vld,
  output logic por_expire,
  output logic oe
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last       = sel_latched ? SHORT_LAST : LONG_LAST;
  assign por_expire = sel_vld && !oe && supply_ok && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld     <= 1'b0;
      sel_latched <= 1'b0;
      cnt         <= '0;
      oe          <= 1'b0;
    end else if (!sel_vld) begin
      sel_vld     <= 1'b1;
      sel_latched <= sel_pin;
    end else if (!oe) begin
      if (!supply_ok)      cnt <= '0;
      else if (por_expire) oe  <= 1'b1;
      else                 cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/cfg_word_shifter.sv
module cfg_word_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv,
  input  logic [WORD_W-1:0] word_in,
  output logic              take,
  output logic              ser_clk,
  output logic              ser_msb
);
  localparam int unsigned BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh;
  logic [BC_W-1:0]   bitcnt;
  logic              ck;
  logic              word_end;

  assign word_end = adv && ck && (bitcnt == LAST_BIT);
  assign take     = start || word_end;
  assign ser_clk  = ck;
  assign ser_msb  = sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      bitcnt <= '0;
      ck     <= 1'b0;
    end else if (take) begin
      sh     <= word_in;
      bitcnt <= '0;
      ck     <= 1'b0;
    end else if (adv) begin
      ck <= ~ck;
      if (ck) begin
        sh     <= sh << 1;
        bitcnt <= bitcnt + 1'b1;
      end
    end else begin
      ck <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_start_seq.sv
module cfg_start_seq
  import cfg_seq_pkg::*;
#(
  parameter int unsigned CYC_PER_MS = 125000,
  parameter int unsigned SHORT_MS   = 2,
  parameter int unsigned LONG_MS    = 100,
  parameter int unsigned WORD_W     = 8
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              por_short,
  input  logic              supply_ok,
  input  logic              done_sense,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_take,
  output logic              oe_out,
  output logic              cfg_clk,
  output logic              cfg_dat,
  output logic [2:0]        phase
);
  localparam int unsigned SHORT_CYC = por_cycles(1'b1, SHORT_MS, LONG_MS, CYC_PER_MS);
  localparam int unsigned LONG_CYC  = por_cycles(1'b0, SHORT_MS, LONG_MS, CYC_PER_MS);
  localparam int unsigned MAX_CYC   = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
  localparam int unsigned CNT_W     = width_for(MAX_CYC);

  phase_e ph_q, ph_d;

  // named internal events for the checker
  logic sel_latched, sel_vld, por_expire;
  logic start_evt, run_adv;
  logic ser_clk, ser_msb;
  logic streaming;

  cfg_por_timer #(
    .CNT_W    (CNT_W),
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) u_timer (
    .clk        (clk),
    .rst_n      (pwr_rst_n),
    .sel_pin    (por_short),
    .supply_ok  (supply_ok),
    .sel_latched(sel_latched),
    .sel_vld    (sel_vld),
    .por_expire (por_expire),
    .oe         (oe_out)
  );

  assign streaming = (ph_q == PH_RUN);
  assign start_evt = (ph_q == PH_ARM) && !done_sense;
  assign run_adv   = streaming && !done_sense;

  cfg_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (pwr_rst_n),
    .start  (start_evt),
    .adv    (run_adv),
    .word_in(word_in),
    .take   (word_take),
    .ser_clk(ser_clk),
    .ser_msb(ser_msb)
  );

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_POR:  if (por_expire) ph_d = PH_ARM;
      PH_ARM:  ph_d = done_sense ? PH_LOCK : PH_RUN;
      PH_RUN:  if (done_sense) ph_d = PH_DONE;
      PH_LOCK: ph_d = PH_LOCK;
      PH_DONE: ph_d = PH_DONE;
      default: ph_d = PH_POR;
    endcase
  end

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) ph_q <= PH_POR;
    else            ph_q <= ph_d;
  end

  assign cfg_clk = streaming && ser_clk;
  assign cfg_dat = streaming && ser_msb;
  assign phase   = ph_q;

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
  import cfg_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       oe,
  input logic       cfg_clk,
  input logic       cfg_dat,
  input logic       done_sense,
  input logic       sel_vld,
  input logic       sel_latched,
  input logic [2:0] phase
);
  // R2
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |=> (sel_vld && $stable(sel_latched)));
  // R3
  oe_por_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_POR) |-> !oe);
  // R3
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |=> oe);
  // R5
  oe_rise_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> (phase == PH_ARM));
  // R5
  pick_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARM && done_sense) |=> (phase == PH_LOCK));
  // R5
  pick_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARM && !done_sense) |=> (phase == PH_RUN));
  // R6
  lock_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOCK) |=> (phase == PH_LOCK));
  // R6
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOCK) |-> (!cfg_clk && !cfg_dat));
  // R7
  clk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && $past(phase) == PH_RUN) |-> (cfg_clk != $past(cfg_clk)));
  // R7
  dat_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN && $past(phase) == PH_RUN && cfg_dat != $past(cfg_dat))
      |-> (!cfg_clk && $past(cfg_clk)));
  // R9
  done_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |=> (phase == PH_DONE));
  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> (!cfg_clk && !cfg_dat));
endmodule

bind cfg_start_seq cfg_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (pwr_rst_n),
  .oe         (oe_out),
  .cfg_clk    (cfg_clk),
  .cfg_dat    (cfg_dat),
  .done_sense (done_sense),
  .sel_vld    (sel_vld),
  .sel_latched(sel_latched),
  .phase      (phase)
);

// File: tb/sim_cfg_start_seq.sv
`timescale 1ns/1ps
module sim_cfg_start_seq;
  localparam int unsigned CPM = 5;
  localparam int unsigned SMS = 2;
  localparam int unsigned LMS = 100;
  localparam int unsigned W   = 8;
  localparam int unsigned LS  = SMS * CPM;  // 10
  localparam int unsigned LL  = LMS * CPM;  // 500

  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic por_short = 1'b0;
  logic supply_ok = 1'b0;
  logic done_sense = 1'b0;
  logic [W-1:0] word_in;
  logic word_take, oe_out, cfg_clk, cfg_dat;
  logic [2:0] phase;

  int checks = 0;
  int errors = 0;
  int widx;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [W-1:0] wval(input int i);
    return W'(8'hA5 + i * 8'h3B);
  endfunction

  always @(posedge clk or negedge pwr_rst_n)
    if (!pwr_rst_n) widx <= 0;
    else if (word_take) widx <= widx + 1;

  always_comb word_in = wval(widx);

  cfg_start_seq #(.CYC_PER_MS(CPM), .SHORT_MS(SMS), .LONG_MS(LMS), .WORD_W(W)) u0 (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .por_short(por_short), .supply_ok(supply_ok),
    .done_sense(done_sense), .word_in(word_in), .word_take(word_take),
    .oe_out(oe_out), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat), .phase(phase)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic power_up(input logic sel, input logic sup, input logic dn);
    @(negedge clk);
    pwr_rst_n = 1'b0;
    por_short = sel; supply_ok = sup; done_sense = dn;
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", oe_out, 0);
    chk("R1 clk in reset", cfg_clk, 0);
    chk("R1 dat in reset", cfg_dat, 0);
    chk("R1 take in reset", word_take, 0);
    chk("R1 phase in reset", phase, 0);
    pwr_rst_n = 1'b1;
  endtask

  // short delay, high sample -> lockout that nothing but reset clears
  task automatic t_short_lockout();
    power_up(1'b1, 1'b1, 1'b1);
    edges(LS);
    chk("R3 oe low before short expiry", oe_out, 0);
    chk("R2 phase countdown", phase, 0);
    edges(1);
    chk("R3 oe high at short expiry", oe_out, 1);
    chk("R5 phase armed", phase, 1);
    chk("R8 no take when sample high", word_take, 0);
    edges(1);
    chk("R5 high sample locks", phase, 3);
    for (int i = 0; i < 12; i++) begin
      done_sense = i[0];
      supply_ok  = i[1];
      por_short  = i[2];
      edges(1);
      chk("R6 lockout held", phase, 3);
      chk("R6 lockout clk quiet", cfg_clk, 0);
      chk("R6 lockout dat quiet", cfg_dat, 0);
      chk("R3 oe stays high", oe_out, 1);
    end
    power_up(1'b1, 1'b1, 1'b0);
    edges(1);
    chk("R6 reset leaves lockout", phase, 0);
  endtask

  // long delay, select change after capture ignored, stream, then completion
  task automatic t_long_stream();
    logic [W-1:0] w;
    power_up(1'b0, 1'b1, 1'b0);
    edges(1);
    por_short = 1'b1;
    edges(LS + 5);
    chk("R2 late select ignored, oe low", oe_out, 0);
    edges(LL - 1 - (LS + 5));
    chk("R3 oe low before long expiry", oe_out, 0);
    edges(1);
    chk("R3 oe high at long expiry", oe_out, 1);
    chk("R5 armed", phase, 1);
    chk("R8 take in armed cycle", word_take, 1);
    edges(1);
    chk("R5 low sample streams", phase, 2);
    for (int k = 0; k < 4 * W; k++) begin
      w = wval(k / (2 * W));
      chk("R7 clock phase", cfg_clk, k % 2);
      chk("R8 msb-first data", cfg_dat, w[W - 1 - ((k / 2) % W)]);
      chk("R8 take timing", word_take, (k % (2 * W)) == (2 * W - 1));
      edges(1);
    end
    done_sense = 1'b1;
    edges(1);
    chk("R9 complete", phase, 4);
    chk("R9 clk low", cfg_clk, 0);
    chk("R9 dat low", cfg_dat, 0);
    done_sense = 1'b0;
    edges(6);
    chk("R9 stays complete", phase, 4);
    chk("R9 clk stays low", cfg_clk, 0);
  endtask

  // supply-good gating and restart
  task automatic t_supply_gate();
    power_up(1'b1, 1'b0, 1'b0);
    edges(40);
    chk("R4 oe held while supply low", oe_out, 0);
    chk("R4 phase held", phase, 0);
    supply_ok = 1'b1;
    edges(5);
    supply_ok = 1'b0;
    edges(1);
    supply_ok = 1'b1;
    edges(LS - 1);
    chk("R4 restarted count not yet done", oe_out, 0);
    edges(1);
    chk("R4 oe after full restarted interval", oe_out, 1);
    chk("R5 armed after gated count", phase, 1);
  endtask

  initial begin
    t_short_lockout();
    t_long_stream();
    t_supply_gate();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired (all) actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule